// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It steps the analog front end through a fixed cycle of four phases. Each phase has one enable output, and the enables drive the switch network around the integrator. The analog integrator, the reference and the capacitors sit outside the block. The block sees them only through a single comparator bit, which tells it on which side of zero the integrator output lies.

The input is integrated for a fixed number of clocks. At that point the sign of the comparator is latched as the input polarity. The integrator is then ramped back toward zero against the reference while a cascade of BCD decades counts clocks. The count at the zero crossing is the reading, in units of the input-to-reference ratio times the integrate length. With the default parameters, 10,000 counts equal the reference voltage and full scale is 20,000 counts. The block flags readings that run past full scale and readings that are too small to be useful. A run/hold input lets a host freeze the display on the last reading.

Top module: `dsq_sequencer`

## Requirements
- R1: The phase output is one-hot, with bit 0 for auto-zero, bit 1 for signal integrate, bit 2 for de-integrate and bit 3 for zero-integrator. Phases always follow the order auto-zero, integrate, de-integrate, zero-integrator and back to auto-zero. Auto-zero lasts at least AZ_CLKS clocks.
- R2: Signal integrate lasts exactly INT_CLKS clocks (default 10,000). On its last clock the value of cmp_i is captured into pol_o, where 1 means a positive input. pol_o changes at no other time.
- R3: During de-integrate, a zero crossing is a clock on which cmp_i differs from pol_o. The reading equals the number of de-integrate clocks before the crossing clock. It is stored as DIGITS BCD digits, with the least significant digit in bits 3:0.
- R4: If FULL_SCALE+1 de-integrate clocks pass without a crossing, de-integrate ends, ovr_o is set and the reading saturates at FULL_SCALE (default 20,000). A crossing on that final clock counts as a normal reading of FULL_SCALE.
- R5: unr_o is set when a reading that is not an overrange is below UR_LIMIT (default 1,800). ovr_o and unr_o are refreshed together with the reading when de-integrate ends.
- R6: Zero-integrator lasts ZI_NORM clocks (default 150) after a normal reading and ZI_OVR clocks (default 6,200) after an overrange.
- R7: run_i is examined only at the end of auto-zero. While it is low, the sequencer stays in auto-zero and the reading, the flags and the polarity keep their last values. A cycle already in progress always completes.
- R8: busy_o is high exactly while the sequencer is in signal integrate or de-integrate.
- R9: After reset the phase is auto-zero, and busy_o, pol_o, ovr_o, unr_o and the reading are all zero.
- R10: Every BCD digit of the reading stays within 0 to 9. With the default parameters the most significant digit never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | High to convert continuously, low to hold after the current cycle |
| cmp_i | input | 1 | Comparator: 1 when the integrator output is on the positive side |
| phase_o | output | 4 | One-hot phase enables (auto-zero, integrate, de-integrate, zero-integrator) |
| busy_o | output | 1 | High during integrate and de-integrate |
| pol_o | output | 1 | Latched input polarity, 1 = positive |
| ovr_o | output | 1 | Last reading was over full scale |
| unr_o | output | 1 | Last reading was below the underrange limit |
| result_o | output | 4*DIGITS | Last reading as BCD digits, least significant digit in the low nibble |

## Verification
Two situations are the hardest to reach from the ports: the clock on which the count reaches full scale, and a conversion that never crosses zero. At default sizes, both need tens of thousands of clocks and a comparator that stays put. The bench therefore shrinks the phase lengths through parameters. It models the comparator as a ramp that flips a chosen number of clocks into de-integrate, and it places that flip exactly on the full-scale clock, one clock before the underrange limit, on the limit itself, at zero, and never. It also lowers run/hold in the middle of a cycle to show that the cycle finishes and the reading is then frozen.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2,
        PH_ZI  = 2'd3
    } phase_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsq_bcd_decade.sv
module dsq_bcd_decade (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       inc_i,
    output logic [3:0] digit_o,
    output logic       carry_o
);
    logic [3:0] digit_d, digit_q;

    always_comb begin
        digit_d = digit_q;
        if (clr_i) begin
            digit_d = 4'd0;
        end else if (inc_i) begin
            digit_d = (digit_q == 4'd9) ? 4'd0 : digit_q + 4'd1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) digit_q <= 4'd0;
        else         digit_q <= digit_d;
    end

    assign digit_o = digit_q;
    assign carry_o = inc_i && (digit_q == 4'd9);
endmodule

// File: rtl/dsq_bcd_counter.sv
module dsq_bcd_counter #(
    parameter int unsigned DIGITS = 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic                  inc_i,
    output logic [4*DIGITS-1:0]   count_o
);
    logic [DIGITS:0] carry;

    assign carry[0] = inc_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_decade
        dsq_bcd_decade u_dec (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (clr_i),
            .inc_i   (carry[g]),
            .digit_o (count_o[4*g +: 4]),
            .carry_o (carry[g+1])
        );
    end
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
    import dsq_pkg::*;
#(
    parameter int unsigned AZ_CLKS    = 100,
    parameter int unsigned INT_CLKS   = 10000,
    parameter int unsigned FULL_SCALE = 20000,
    parameter int unsigned UR_LIMIT   = 1800,
    parameter int unsigned ZI_NORM    = 150,
    parameter int unsigned ZI_OVR     = 6200,
    parameter int unsigned DIGITS     = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    input  logic                cmp_i,
    output logic [3:0]          phase_o,
    output logic                busy_o,
    output logic                pol_o,
    output logic                ovr_o,
    output logic                unr_o,
    output logic [4*DIGITS-1:0] result_o
);
    localparam int unsigned MAXV = max2(max2(AZ_CLKS, INT_CLKS), max2(FULL_SCALE, max2(ZI_NORM, ZI_OVR)));
    localparam int unsigned TW   = $clog2(MAXV + 1);

    localparam logic [TW-1:0] AZ_LAST   = TW'(AZ_CLKS - 1);
    localparam logic [TW-1:0] INT_LAST  = TW'(INT_CLKS - 1);
    localparam logic [TW-1:0] FS_CNT    = TW'(FULL_SCALE);
    localparam logic [TW-1:0] UR_CNT    = TW'(UR_LIMIT);
    localparam logic [TW-1:0] ZIN_LAST  = TW'(ZI_NORM - 1);
    localparam logic [TW-1:0] ZIO_LAST  = TW'(ZI_OVR - 1);

    typedef struct packed {
        phase_t                phase;
        logic [TW-1:0]         tmr;
        logic                  pol;
        logic                  zi_long;
        logic                  ovr;
        logic                  unr;
        logic [4*DIGITS-1:0]   res;
    } state_t;

    state_t s_d, s_q;

    logic                cnt_clr;
    logic                cnt_inc;
    logic [4*DIGITS-1:0] cnt_bcd;

    dsq_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .count_o (cnt_bcd)
    );

    always_comb begin
        s_d     = s_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (s_q.phase)
            PH_AZ: begin
                if (s_q.tmr != AZ_LAST) begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end else if (run_i) begin
                    s_d.phase = PH_INT;
                    s_d.tmr   = '0;
                end
            end
            PH_INT: begin
                cnt_clr = 1'b1;
                if (s_q.tmr == INT_LAST) begin
                    s_d.phase = PH_DE;
                    s_d.tmr   = '0;
                    s_d.pol   = cmp_i;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            PH_DE: begin
                if (cmp_i != s_q.pol) begin
                    s_d.phase   = PH_ZI;
                    s_d.tmr     = '0;
                    s_d.res     = cnt_bcd;
                    s_d.ovr     = 1'b0;
                    s_d.unr     = (s_q.tmr < UR_CNT);
                    s_d.zi_long = 1'b0;
                end else if (s_q.tmr == FS_CNT) begin
                    s_d.phase   = PH_ZI;
                    s_d.tmr     = '0;
                    s_d.res     = cnt_bcd;
                    s_d.ovr     = 1'b1;
                    s_d.unr     = 1'b0;
                    s_d.zi_long = 1'b1;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                    cnt_inc = 1'b1;
                end
            end
            PH_ZI: begin
                if (s_q.tmr == (s_q.zi_long ? ZIO_LAST : ZIN_LAST)) begin
                    s_d.phase = PH_AZ;
                    s_d.tmr   = '0;
                end else begin
                    s_d.tmr = s_q.tmr + 1'b1;
                end
            end
            default: s_d.phase = PH_AZ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_AZ, tmr: '0, pol: 1'b0, zi_long: 1'b0,
                     ovr: 1'b0, unr: 1'b0, res: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o  = 4'(1) << s_q.phase;
    assign busy_o   = (s_q.phase == PH_INT) || (s_q.phase == PH_DE);
    assign pol_o    = s_q.pol;
    assign ovr_o    = s_q.ovr;
    assign unr_o    = s_q.unr;
    assign result_o = s_q.res;
endmodule

// File: rtl/dsq_sequencer_chk.sv
module dsq_sequencer_chk #(
    parameter int unsigned DIGITS = 5,
    parameter int unsigned FULL_SCALE = 20000
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [3:0]          phase_o,
    input logic                busy_o,
    input logic                pol_o,
    input logic                ovr_o,
    input logic                unr_o,
    input logic [4*DIGITS-1:0] result_o
);
    localparam int unsigned MSD_MAX = (FULL_SCALE / (10 ** (DIGITS - 1))) % 10;

    a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(phase_o) == 1);
    a_r1_az_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o[0] |=> (phase_o[0] || phase_o[1]));
    a_r1_int_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o[1] |=> (phase_o[1] || phase_o[2]));
    a_r1_de_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o[2] |=> (phase_o[2] || phase_o[3]));
    a_r1_zi_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o[3] |=> (phase_o[3] || phase_o[0]));
    a_r2_pol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_o[1] |=> $stable(pol_o));
    a_r3_res_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_o[2] |=> ($stable(result_o) && $stable(ovr_o) && $stable(unr_o)));
    a_r5_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ovr_o && unr_o));
    a_r8_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> phase_o[1]);
    a_r8_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> phase_o[3]);
    a_r10_msd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        result_o[4*DIGITS-1 -: 4] <= 4'(MSD_MAX));

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        a_r10_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
            result_o[4*g +: 4] <= 4'd9);
    end
endmodule

bind dsq_sequencer dsq_sequencer_chk #(.DIGITS(DIGITS), .FULL_SCALE(FULL_SCALE)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_o  (phase_o),
    .busy_o   (busy_o),
    .pol_o    (pol_o),
    .ovr_o    (ovr_o),
    .unr_o    (unr_o),
    .result_o (result_o)
);

// File: tb/dsq_sequencer_tb_top.sv
module dsq_sequencer_tb_top;
    localparam int AZ = 6, INTC = 40, FS = 80, UR = 9, ZIN = 5, ZIO = 30, DIG = 5;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b1, cmp = 1'b0;
    logic [3:0] phase;
    logic busy, pol, ovr, unr;
    logic [4*DIG-1:0] res;

    int errors = 0, checks = 0;
    int v_cross = 0;
    logic sgn = 1'b1;

    int m_ph, m_t, m_zl, m_res;
    logic m_pol, m_ovr, m_unr;

    always #2.5 clk = ~clk;

    dsq_sequencer #(.AZ_CLKS(AZ), .INT_CLKS(INTC), .FULL_SCALE(FS), .UR_LIMIT(UR),
                    .ZI_NORM(ZIN), .ZI_OVR(ZIO), .DIGITS(DIG)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_i(cmp),
        .phase_o(phase), .busy_o(busy), .pol_o(pol), .ovr_o(ovr), .unr_o(unr),
        .result_o(res));

    function automatic logic [4*DIG-1:0] to_bcd(input int v);
        logic [4*DIG-1:0] b = '0;
        int x = v;
        for (int i = 0; i < DIG; i++) begin
            b[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, phase numbers 0..3 = AZ, INT, DE, ZI
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_t = 0; m_pol = 0; m_ovr = 0; m_unr = 0; m_res = 0; m_zl = ZIN;
        end else begin
            case (m_ph)
                0: if (m_t < AZ - 1) m_t++; else if (run) begin m_ph = 1; m_t = 0; end
                1: if (m_t == INTC - 1) begin m_pol = cmp; m_ph = 2; m_t = 0; end else m_t++;
                2: if (cmp != m_pol) begin
                       m_res = m_t; m_ovr = 0; m_unr = (m_t < UR); m_zl = ZIN; m_ph = 3; m_t = 0;
                   end else if (m_t == FS) begin
                       m_res = FS; m_ovr = 1; m_unr = 0; m_zl = ZIO; m_ph = 3; m_t = 0;
                   end else m_t++;
                default: if (m_t == m_zl - 1) begin m_ph = 0; m_t = 0; end else m_t++;
            endcase
        end
    end

    // per-cycle comparison and comparator ramp model
    always @(negedge clk) begin
        if (rst_n) begin
            check(phase == 4'(1 << m_ph), "R1 phase", phase, 4'(1 << m_ph));
            check(busy == (m_ph == 1 || m_ph == 2), "R8 busy", busy, (m_ph == 1 || m_ph == 2));
            check(pol == m_pol, "R2 pol", pol, m_pol);
            check(res == to_bcd(m_res), "R3 result", res, to_bcd(m_res));
            check(ovr == m_ovr, "R4 ovr", ovr, m_ovr);
            check(unr == m_unr, "R5 unr", unr, m_unr);
        end
        cmp = (rst_n && m_ph == 2 && m_t >= v_cross) ? ~sgn : sgn;
    end

    task automatic conv(input int v, input logic s, input int e_res, input logic e_ovr, input logic e_unr);
        int n;
        do @(negedge clk); while (phase != 4'b0001);
        v_cross = v; sgn = s;
        do @(negedge clk); while (phase != 4'b0010);
        n = 0;
        while (phase == 4'b0010) begin n++; @(negedge clk); end
        check(n == INTC, "R2 integrate length", n, INTC);
        check(pol == s, "R2 polarity latch", pol, s);
        check(busy == 1'b1, "R8 busy in de-integrate", busy, 1);
        do @(negedge clk); while (phase != 4'b1000);
        check(res == to_bcd(e_res), "R3 reading", res, to_bcd(e_res));
        check(ovr == e_ovr, "R4 overrange flag", ovr, e_ovr);
        check(unr == e_unr, "R5 underrange flag", unr, e_unr);
        n = 0;
        while (phase == 4'b1000) begin n++; @(negedge clk); end
        check(n == (e_ovr ? ZIO : ZIN), "R6 zero-integrator length", n, e_ovr ? ZIO : ZIN);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(phase == 4'b0001 && !busy && !pol && !ovr && !unr && res == '0,
              "R9 reset state", {phase, busy, pol, ovr, unr, res}, 4'b0001 << 24);
        rst_n = 1'b1;
        conv(37, 1'b1, 37, 1'b0, 1'b0);
        conv(0, 1'b0, 0, 1'b0, 1'b1);
        conv(8, 1'b1, 8, 1'b0, 1'b1);
        conv(9, 1'b0, 9, 1'b0, 1'b0);
        conv(80, 1'b1, 80, 1'b0, 1'b0);
        conv(200, 1'b0, 80, 1'b1, 1'b0);
        conv(12, 1'b1, 12, 1'b0, 1'b0);
        // R7: hold lowered mid-cycle
        do @(negedge clk); while (phase != 4'b0001);
        v_cross = 21; sgn = 1'b1;
        do @(negedge clk); while (phase != 4'b0010);
        run = 1'b0;
        do @(negedge clk); while (phase != 4'b1000);
        do @(negedge clk); while (phase != 4'b0001);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            if (phase != 4'b0001) n++;
            @(negedge clk);
        end
        check(n == 0, "R7 stays in auto-zero", n, 0);
        check(res == to_bcd(21) && pol == 1'b1, "R7 reading held", res, to_bcd(21));
        run = 1'b1;
        conv(50, 1'b0, 50, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule